// File: doc/BRIEF.md
# PLL divider search engine

This block searches for the divider settings of a clock synthesiser that best reproduce a requested output frequency. Software, or a mode-setting sequencer, sets up the reference frequency, the allowed VCO and phase-detector input windows, the reference and feedback divider ranges, an optional preferred VCO frequency, an optional fixed post divider, and two small tables. One table lists the post dividers and the other lists the extra post dividers, each with the register code that selects it. It then pulses `start` with a target frequency in Hz.

The engine walks every allowed combination. For each pair of table entries it prunes on the VCO window. For each reference divider it prunes on the input window. It then derives the feedback divider and the achieved frequency with rounded divisions, which a 64-bit restoring divider performs one quotient bit per clock. It keeps the best candidate under an error rule that can give way to VCO proximity. When the walk ends, `done` pulses for one cycle. At that point the chosen dividers, their codes and the achieved frequency appear on the result ports, and they hold until the next search finishes.

Frequencies other than the target and the achieved frequency are given in units of 10 kHz.

Top module: `pll_div_search`

## Requirements
- R1: While reset is held, and after it is released until the first search finishes, `busy`, `done` and `nosol` are 0 and every result port is 0.
- R2: A `start` seen while `busy` is 0 begins a search, and `busy` reads 1 from the next cycle. A `start` seen while `busy` is 1 is ignored and does not change the result. `done` is a single-cycle pulse, with `busy` at 0 in that cycle.
- R3: The extra-post table is the outer loop, the post table the middle loop and the reference divider the inner loop, ascending. Within each table the first entry whose divider value is 0 ends the table, so entries after it are never used.
- R4: A post pair is skipped when floor(target/10000) × post × extra_post lies outside [vco_min, vco_max].
- R5: A reference divider r in [ref_min, ref_max] is skipped when floor(ref_freq / r) lies outside [pin_min, pin_max]. A reported solution always has its reference divider inside [ref_min, ref_max].
- R6: The feedback divider is round(target × r × post / (ref_freq × 10000 × xfb)), where round(a/b) = floor((a + floor(b/2)) / b). A candidate whose feedback divider is outside [fb_min, fb_max] is skipped.
- R7: The achieved frequency is round(ref_freq × 10000 × fb × xfb / (r × post)), and the error is its absolute difference from the target.
- R8: With `best_vco` at 0, a candidate replaces the held best only if its error is strictly smaller. The held best error starts at 999999999.
- R9: With `best_vco` nonzero, a candidate replaces the held best if its error plus 100 is below the best error. It also replaces it if the two errors differ by less than 100 and its VCO value is strictly closer to `best_vco`.
- R10: A nonzero `fixed_post` limits the middle loop to the first post entry before the terminator whose divider equals it. If no such entry exists, nothing is searched.
- R11: If no candidate passes every check, `done` still pulses with `nosol` at 1. The reported values are then reference 1, feedback 1, achieved frequency 0, and the divider values and codes of entry 0 of each table.
- R12: The result ports and `nosol` change only in the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| target_hz | input | FW | Requested output frequency in Hz |
| ref_freq | input | CW | Reference frequency, 10 kHz units |
| vco_min | input | CW | Lowest allowed VCO value |
| vco_max | input | CW | Highest allowed VCO value |
| pin_min | input | CW | Lowest allowed phase-detector input |
| pin_max | input | CW | Highest allowed phase-detector input |
| ref_min | input | RW | First reference divider tried |
| ref_max | input | RW | Last reference divider tried |
| fb_min | input | BW | Smallest legal feedback divider |
| fb_max | input | BW | Largest legal feedback divider |
| xfb | input | PW | Fixed extra feedback factor |
| best_vco | input | CW | Preferred VCO value, 0 for none |
| fixed_post | input | PW | Required post divider, 0 for free choice |
| post_tbl | input | NPOST*PW | Post divider values, entry i at bits i*PW |
| post_code | input | NPOST*KW | Register codes of the post entries |
| xpost_tbl | input | NXP*PW | Extra post divider values |
| xpost_code | input | NXP*KW | Register codes of the extra post entries |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are loaded |
| nosol | output | 1 | No candidate passed all checks |
| res_ref | output | RW | Chosen reference divider |
| res_fb | output | BW | Chosen feedback divider |
| res_post | output | PW | Chosen post divider value |
| res_post_code | output | KW | Its register code |
| res_xpost | output | PW | Chosen extra post divider value |
| res_xpost_code | output | KW | Its register code |
| res_freq | output | FW | Achieved frequency in Hz |

## Verification
The bench builds the block with its default parameters. These give a 32-bit target, room for eight post entries and four extra-post entries, and a full 64-bit divider.

With those sizes it loads a post table that holds a value after its terminator, which brings the end-of-table rule and the fixed-post lookup within reach. It also uses a small reference range whose two ends fail the input window. Its feedback and VCO limits can be narrowed so that each pruning step rejects some candidates and not others.

The hysteresis rule is exercised with two different preferred VCO values against the same target.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW       = 32,
  parameter int CW       = 16,
  parameter int RW       = 10,
  parameter int BW       = 11,
  parameter int PW       = 8,
  parameter int KW       = 4,
  parameter int NPOST    = 8,
  parameter int NXP      = 4,
  parameter int DW       = 64,
  parameter int ERR_INIT = 999999999,
  parameter int HYST     = 100,
  parameter int UNIT     = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FW-1:0]       target_hz,
  input  logic [CW-1:0]       ref_freq,
  input  logic [CW-1:0]       vco_min,
  input  logic [CW-1:0]       vco_max,
  input  logic [CW-1:0]       pin_min,
  input  logic [CW-1:0]       pin_max,
  input  logic [RW-1:0]       ref_min,
  input  logic [RW-1:0]       ref_max,
  input  logic [BW-1:0]       fb_min,
  input  logic [BW-1:0]       fb_max,
  input  logic [PW-1:0]       xfb,
  input  logic [CW-1:0]       best_vco,
  input  logic [PW-1:0]       fixed_post,
  input  logic [NPOST*PW-1:0] post_tbl,
  input  logic [NPOST*KW-1:0] post_code,
  input  logic [NXP*PW-1:0]   xpost_tbl,
  input  logic [NXP*KW-1:0]   xpost_code,
  output logic                busy,
  output logic                done,
  output logic                nosol,
  output logic [RW-1:0]       res_ref,
  output logic [BW-1:0]       res_fb,
  output logic [PW-1:0]       res_post,
  output logic [KW-1:0]       res_post_code,
  output logic [PW-1:0]       res_xpost,
  output logic [KW-1:0]       res_xpost_code,
  output logic [FW-1:0]       res_freq
);

  localparam int PIW = $clog2(NPOST + 1);
  localparam int XIW = $clog2(NXP + 1);
  localparam int NPS = 2 ** PIW;
  localparam int NXS = 2 ** XIW;
  localparam int PPW = 2 * PW;
  localparam int VW  = FW + PPW;
  localparam int PNW = CW + RW + 2;
  localparam int DCW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_SCALE, S_XP, S_PP, S_RD, S_FBW, S_FQW} st_t;

  st_t state;

  logic [PW-1:0] pt [NPS];
  logic [KW-1:0] pc [NPS];
  logic [PW-1:0] xt [NXS];
  logic [KW-1:0] xc [NXS];

  genvar g;
  generate
    for (g = 0; g < NPS; g++) begin : g_post
      if (g < NPOST) begin : g_used
        assign pt[g] = post_tbl[g*PW +: PW];
        assign pc[g] = post_code[g*KW +: KW];
      end else begin : g_pad
        assign pt[g] = '0;
        assign pc[g] = '0;
      end
    end
    for (g = 0; g < NXS; g++) begin : g_xpost
      if (g < NXP) begin : g_used
        assign xt[g] = xpost_tbl[g*PW +: PW];
        assign xc[g] = xpost_code[g*KW +: KW];
      end else begin : g_pad
        assign xt[g] = '0;
        assign xc[g] = '0;
      end
    end
  endgenerate

  logic [FW-1:0]  t_hz, t10k;
  logic [XIW-1:0] xi;
  logic [PIW-1:0] pi, fix_idx;
  logic           fend;
  logic [RW:0]    rd;
  logic [PPW-1:0] cur_post;
  logic [VW-1:0]  cur_vco;
  logic [BW-1:0]  cur_fb;

  logic [DW-1:0]  best_err;
  logic [VW-1:0]  best_vdev;
  logic           found;
  logic [RW-1:0]  best_ref;
  logic [BW-1:0]  best_fb;
  logic [PW-1:0]  best_pv, best_xv;
  logic [KW-1:0]  best_pc, best_xc;
  logic [FW-1:0]  best_freq;

  logic [DW-1:0]  dq, drem, dden;
  logic [DCW-1:0] dcnt;
  logic [DW:0]    rsh, rsub;
  logic           take, div_rdy;

  assign rsh     = {drem, dq[DW-1]};
  assign rsub    = rsh - {1'b0, dden};
  assign take    = !rsub[DW];
  assign div_rdy = (dcnt == '0);

  always_comb begin
    fix_idx = PIW'(NPOST);
    fend    = 1'b0;
    for (int i = 0; i < NPOST; i++) begin
      if (pt[i] == '0) fend = 1'b1;
      else if (!fend && fix_idx == PIW'(NPOST) && pt[i] == fixed_post) fix_idx = PIW'(i);
    end
  end

  logic [PW-1:0]  pv, xv;
  logic [PPW-1:0] post_prod;
  logic [VW-1:0]  vco_calc;
  logic           vco_ok;
  assign pv        = pt[pi];
  assign xv        = xt[xi];
  assign post_prod = PPW'(pv) * PPW'(xv);
  assign vco_calc  = VW'(t10k) * VW'(post_prod);
  assign vco_ok    = vco_calc >= VW'(vco_min) && vco_calc <= VW'(vco_max);

  logic [PNW-1:0] lo_lim, hi_lim;
  logic           pin_ok, rd_over;
  assign lo_lim  = PNW'(pin_min) * PNW'(rd);
  assign hi_lim  = (PNW'(pin_max) + PNW'(1)) * PNW'(rd);
  assign pin_ok  = PNW'(ref_freq) >= lo_lim && PNW'(ref_freq) < hi_lim;
  assign rd_over = rd > (RW+1)'(ref_max);

  logic [DW-1:0] fb_den, fb_num, fq_den, fq_num;
  logic          fb_ok;
  assign fb_den = DW'(ref_freq) * DW'(UNIT) * DW'(xfb);
  assign fb_num = DW'(t_hz) * DW'(rd) * DW'(cur_post) + (fb_den >> 1);
  assign fq_den = DW'(rd) * DW'(cur_post);
  assign fq_num = DW'(ref_freq) * DW'(UNIT) * DW'(dq[BW-1:0]) * DW'(xfb) + (fq_den >> 1);
  assign fb_ok  = dq >= DW'(fb_min) && dq <= DW'(fb_max);

  logic [DW-1:0] err, ediff;
  logic [VW-1:0] vdev;
  logic          accept;
  assign err    = (dq >= DW'(t_hz)) ? dq - DW'(t_hz) : DW'(t_hz) - dq;
  assign ediff  = (err >= best_err) ? err - best_err : best_err - err;
  assign vdev   = (cur_vco >= VW'(best_vco)) ? cur_vco - VW'(best_vco) : VW'(best_vco) - cur_vco;
  assign accept = (best_vco == '0) ? (err < best_err)
                : ((err + DW'(HYST) < best_err) || (ediff < DW'(HYST) && vdev < best_vdev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      busy <= 1'b0; done <= 1'b0; nosol <= 1'b0;
      res_ref <= '0; res_fb <= '0; res_post <= '0; res_post_code <= '0;
      res_xpost <= '0; res_xpost_code <= '0; res_freq <= '0;
      t_hz <= '0; t10k <= '0; xi <= '0; pi <= '0; rd <= '0;
      cur_post <= '0; cur_vco <= '0; cur_fb <= '0;
      best_err <= '0; best_vdev <= '0; found <= 1'b0;
      best_ref <= '0; best_fb <= '0; best_pv <= '0; best_xv <= '0;
      best_pc <= '0; best_xc <= '0; best_freq <= '0;
      dq <= '0; drem <= '0; dden <= '0; dcnt <= '0;
    end else begin
      done <= 1'b0;
      if (!div_rdy) begin
        dq   <= {dq[DW-2:0], take};
        drem <= take ? rsub[DW-1:0] : rsh[DW-1:0];
        dcnt <= dcnt - DCW'(1);
      end
      case (state)
        S_IDLE: if (start) begin
          busy <= 1'b1;
          t_hz <= target_hz;
          dq   <= DW'(target_hz);
          dden <= DW'(UNIT);
          drem <= '0;
          dcnt <= DCW'(DW);
          state <= S_SCALE;
        end
        S_SCALE: if (div_rdy) begin
          t10k      <= dq[FW-1:0];
          xi        <= '0;
          best_err  <= DW'(ERR_INIT);
          best_vdev <= '1;
          found     <= 1'b0;
          best_ref  <= RW'(1);
          best_fb   <= BW'(1);
          best_pv   <= pt[0];
          best_pc   <= pc[0];
          best_xv   <= xt[0];
          best_xc   <= xc[0];
          best_freq <= '0;
          state     <= S_XP;
        end
        S_XP: begin
          if (xv == '0) begin
            busy           <= 1'b0;
            done           <= 1'b1;
            nosol          <= !found;
            res_ref        <= best_ref;
            res_fb         <= best_fb;
            res_post       <= best_pv;
            res_post_code  <= best_pc;
            res_xpost      <= best_xv;
            res_xpost_code <= best_xc;
            res_freq       <= best_freq;
            state          <= S_IDLE;
          end else begin
            pi    <= (fixed_post != '0) ? fix_idx : '0;
            state <= S_PP;
          end
        end
        S_PP: begin
          if (pv == '0 || (fixed_post != '0 && pi != fix_idx)) begin
            xi    <= xi + XIW'(1);
            state <= S_XP;
          end else if (!vco_ok) begin
            pi <= pi + PIW'(1);
          end else begin
            cur_post <= post_prod;
            cur_vco  <= vco_calc;
            rd       <= (RW+1)'(ref_min);
            state    <= S_RD;
          end
        end
        S_RD: begin
          if (rd_over) begin
            pi    <= pi + PIW'(1);
            state <= S_PP;
          end else if (!pin_ok) begin
            rd <= rd + (RW+1)'(1);
          end else begin
            dq    <= fb_num;
            dden  <= fb_den;
            drem  <= '0;
            dcnt  <= DCW'(DW);
            state <= S_FBW;
          end
        end
        S_FBW: if (div_rdy) begin
          if (!fb_ok) begin
            rd    <= rd + (RW+1)'(1);
            state <= S_RD;
          end else begin
            cur_fb <= dq[BW-1:0];
            dq     <= fq_num;
            dden   <= fq_den;
            drem   <= '0;
            dcnt   <= DCW'(DW);
            state  <= S_FQW;
          end
        end
        S_FQW: if (div_rdy) begin
          if (accept) begin
            found     <= 1'b1;
            best_err  <= err;
            best_vdev <= vdev;
            best_ref  <= rd[RW-1:0];
            best_fb   <= cur_fb;
            best_pv   <= pv;
            best_pc   <= pc[pi];
            best_xv   <= xv;
            best_xc   <= xc[xi];
            best_freq <= dq[FW-1:0];
          end
          rd    <= rd + (RW+1)'(1);
          state <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({nosol, res_ref, res_fb, res_post, res_post_code,
                       res_xpost, res_xpost_code, res_freq})); // R12
  AST_FB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !nosol) |-> (res_fb >= fb_min && res_fb <= fb_max)); // R6
  AST_REF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !nosol) |-> (res_ref >= ref_min && res_ref <= ref_max)); // R5
  AST_NOSOL_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nosol) |-> (res_ref == RW'(1) && res_fb == BW'(1) && res_freq == '0)); // R11

endmodule

// File: tb/test_pll_div_search.sv
module test_pll_div_search;
  localparam int FW = 32, CW = 16, RW = 10, BW = 11, PW = 8, KW = 4;
  localparam int NPOST = 8, NXP = 4;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] target_hz = '0;

  longint cfg_rf, cfg_vmin, cfg_vmax, cfg_pmin, cfg_pmax, cfg_rmin, cfg_rmax;
  longint cfg_fbmin, cfg_fbmax, cfg_xfb, cfg_bv, cfg_fixed;
  int bpt [NPOST];
  int bpc [NPOST];
  int bxt [NXP];
  int bxc [NXP];

  logic [CW-1:0] ref_freq, vco_min, vco_max, pin_min, pin_max, best_vco;
  logic [RW-1:0] ref_min, ref_max;
  logic [BW-1:0] fb_min, fb_max;
  logic [PW-1:0] xfb, fixed_post;
  logic [NPOST*PW-1:0] post_tbl;
  logic [NPOST*KW-1:0] post_code;
  logic [NXP*PW-1:0]   xpost_tbl;
  logic [NXP*KW-1:0]   xpost_code;

  assign ref_freq   = cfg_rf[CW-1:0];
  assign vco_min    = cfg_vmin[CW-1:0];
  assign vco_max    = cfg_vmax[CW-1:0];
  assign pin_min    = cfg_pmin[CW-1:0];
  assign pin_max    = cfg_pmax[CW-1:0];
  assign ref_min    = cfg_rmin[RW-1:0];
  assign ref_max    = cfg_rmax[RW-1:0];
  assign fb_min     = cfg_fbmin[BW-1:0];
  assign fb_max     = cfg_fbmax[BW-1:0];
  assign xfb        = cfg_xfb[PW-1:0];
  assign best_vco   = cfg_bv[CW-1:0];
  assign fixed_post = cfg_fixed[PW-1:0];

  always_comb begin
    for (int i = 0; i < NPOST; i++) begin
      post_tbl[i*PW +: PW]  = bpt[i][PW-1:0];
      post_code[i*KW +: KW] = bpc[i][KW-1:0];
    end
    for (int i = 0; i < NXP; i++) begin
      xpost_tbl[i*PW +: PW]  = bxt[i][PW-1:0];
      xpost_code[i*KW +: KW] = bxc[i][KW-1:0];
    end
  end

  logic busy, done, nosol;
  logic [RW-1:0] res_ref;
  logic [BW-1:0] res_fb;
  logic [PW-1:0] res_post, res_xpost;
  logic [KW-1:0] res_post_code, res_xpost_code;
  logic [FW-1:0] res_freq;

  pll_div_search i_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .ref_freq(ref_freq), .vco_min(vco_min), .vco_max(vco_max),
    .pin_min(pin_min), .pin_max(pin_max), .ref_min(ref_min), .ref_max(ref_max),
    .fb_min(fb_min), .fb_max(fb_max), .xfb(xfb), .best_vco(best_vco),
    .fixed_post(fixed_post), .post_tbl(post_tbl), .post_code(post_code),
    .xpost_tbl(xpost_tbl), .xpost_code(xpost_code),
    .busy(busy), .done(done), .nosol(nosol), .res_ref(res_ref), .res_fb(res_fb),
    .res_post(res_post), .res_post_code(res_post_code), .res_xpost(res_xpost),
    .res_xpost_code(res_xpost_code), .res_freq(res_freq)
  );

  int tot = 0, bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tot++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", tot, bad);
    finished = 1'b1;
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !finished) begin
      bad++;
      tot++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      summary();
    end
  end

  // per-clock monitor: pulse shape of done and hold of results
  logic [RW+BW+2*PW+2*KW+FW:0] prev_bundle;
  bit have_prev = 1'b0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [RW+BW+2*PW+2*KW+FW:0] b =
        {nosol, res_ref, res_fb, res_post, res_post_code, res_xpost, res_xpost_code, res_freq};
      if (done) begin
        chk("R2", "busy during done", busy, 0);
        chk("R2", "done width", prev_done, 0);
      end else if (have_prev) begin
        chk("R12", "result hold", (b == prev_bundle) ? 1 : 0, 1);
      end
      prev_bundle = b;
      have_prev = 1'b1;
      prev_done = done;
    end
  end

  bit     exp_ok;
  longint exp_ref, exp_fb, exp_pv, exp_pc, exp_xv, exp_xc, exp_fr;

  function automatic longint rdiv(input longint a, input longint b);
    return (a + b / 2) / b;
  endfunction

  task automatic model(input longint tgt);
    longint berr, bvd, t10k, post, vco, pin, fb, fr, err, vd, ed;
    int lo, hi;
    berr = 999999999; bvd = 64'h7fff_ffff_ffff_ffff;
    exp_ok = 0; exp_ref = 1; exp_fb = 1; exp_fr = 0;
    exp_pv = bpt[0]; exp_pc = bpc[0]; exp_xv = bxt[0]; exp_xc = bxc[0];
    t10k = tgt / 10000;
    for (int x = 0; x < NXP && bxt[x] != 0; x++) begin
      lo = -1; hi = -1;
      if (cfg_fixed != 0) begin
        for (int i = 0; i < NPOST && bpt[i] != 0; i++)
          if (lo < 0 && bpt[i] == cfg_fixed) lo = i;
        hi = lo;
      end else begin
        lo = 0;
        for (int i = 0; i < NPOST && bpt[i] != 0; i++) hi = i;
      end
      if (lo < 0) continue;
      for (int p = lo; p <= hi; p++) begin
        post = longint'(bpt[p]) * bxt[x];
        vco = t10k * post;
        if (vco < cfg_vmin || vco > cfg_vmax) continue;
        for (longint r = cfg_rmin; r <= cfg_rmax; r++) begin
          pin = cfg_rf / r;
          if (pin < cfg_pmin || pin > cfg_pmax) continue;
          fb = rdiv(tgt * r * post, cfg_rf * 10000 * cfg_xfb);
          if (fb < cfg_fbmin || fb > cfg_fbmax) continue;
          fr = rdiv(cfg_rf * 10000 * fb * cfg_xfb, r * post);
          err = (fr > tgt) ? fr - tgt : tgt - fr;
          vd = (vco > cfg_bv) ? vco - cfg_bv : cfg_bv - vco;
          ed = (err > berr) ? err - berr : berr - err;
          if ((cfg_bv == 0 && err < berr) ||
              (cfg_bv != 0 && (err < berr - 100 || (ed < 100 && vd < bvd)))) begin
            berr = err; bvd = vd; exp_ok = 1;
            exp_ref = r; exp_fb = fb; exp_fr = fr;
            exp_pv = bpt[p]; exp_pc = bpc[p]; exp_xv = bxt[x]; exp_xc = bxc[x];
          end
        end
      end
    end
  endtask

  task automatic run(input string req, input longint tgt, input bit restart);
    model(tgt);
    @(negedge clk);
    target_hz = tgt[FW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", busy, 1);
    if (restart) begin
      target_hz = FW'(tgt + 777777);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      target_hz = tgt[FW-1:0];
    end
    while (!done) @(negedge clk);
    chk(req, "nosol", nosol, exp_ok ? 0 : 1);
    chk(req, "ref", res_ref, exp_ref);
    chk(req, "fb", res_fb, exp_fb);
    chk(req, "post", res_post, exp_pv);
    chk(req, "post code", res_post_code, exp_pc);
    chk(req, "xpost", res_xpost, exp_xv);
    chk(req, "xpost code", res_xpost_code, exp_xc);
    chk(req, "freq", res_freq, exp_fr);
  endtask

  task automatic base_cfg();
    cfg_rf = 270; cfg_vmin = 1000; cfg_vmax = 5000; cfg_pmin = 20; cfg_pmax = 100;
    cfg_rmin = 2; cfg_rmax = 14; cfg_fbmin = 4; cfg_fbmax = 2047; cfg_xfb = 1;
    cfg_bv = 0; cfg_fixed = 0;
  endtask

  initial begin
    base_cfg();
    bpt = '{1, 2, 4, 8, 0, 3, 0, 0};
    bpc = '{0, 1, 2, 3, 0, 5, 0, 0};
    bxt = '{1, 2, 0, 0};
    bxc = '{0, 4, 0, 0};
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "fb in reset", res_fb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "nosol after reset", nosol, 0);
    chk("R1", "ref after reset", res_ref, 0);
    chk("R1", "freq after reset", res_freq, 0);

    run("R8", 12345678, 1'b1);           // R2: second start ignored
    cfg_bv = 3000; run("R9", 12345678, 1'b0);
    cfg_bv = 4900; run("R9", 12345678, 1'b0);
    cfg_bv = 0; cfg_fixed = 4; run("R10", 12345678, 1'b0);
    cfg_fixed = 3; run("R3", 12345678, 1'b0);  // entry after terminator
    cfg_fixed = 5; run("R11", 12345678, 1'b0);
    cfg_fixed = 0; cfg_vmin = 2000; cfg_vmax = 3000; run("R4", 12345678, 1'b0);
    base_cfg(); run("R11", 100000, 1'b0);
    cfg_fbmax = 60; cfg_xfb = 2; run("R6", 12345678, 1'b0);
    base_cfg(); cfg_pmin = 40; cfg_pmax = 60; run("R5", 12345678, 1'b0);
    base_cfg(); run("R7", 25000000, 1'b0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule